// File: doc/BRIEF.md
# Address-Encoded NAND Command Sequencer

This block is a write-only bus slave that turns 32-bit writes into byte cycles on an 8-bit NAND flash bus. It has no control registers. Each write carries its own instructions in the address offset: one address bit picks command phase or data phase, and further fields give the opcodes, the number of address cycles, a last-chunk ECC flag, and a trailing-command flag. The write data supplies the address bytes or the data bytes. Each byte goes out with a write-strobe pulse of fixed width, least-significant byte first. Chip enable is held low for the whole operation.

A command-phase write sends one opcode byte with CLE high. It then sends up to four address bytes with ALE high. If more than four address cycles are requested, the sequencer keeps chip enable low and waits for a second write, whose data carries the remaining address bytes. A data-phase write sends its four bytes as plain data. It can flag the final chunk of a transfer, which raises a one-cycle `ecc_last` pulse. It can also append a confirm opcode after the last data byte, as a page program does. After such a trailing opcode, the sequencer waits a guard time and then until the ready/busy line reports ready. The bus ready output is low while the sequencer is busy, so the next write is held back.

The control state machine has five states:
- ST_IDLE: chip enable high, ready high.
- ST_SHIFT: bytes are being sent.
- ST_WAIT2: waiting for the second address write; chip enable low, ready high.
- ST_GUARD: a fixed count of TWB_CYC cycles after a trailing opcode.
- ST_WAIT_RB: waiting for the ready/busy input to go high.

The transitions are:
- ST_IDLE to ST_SHIFT on an accepted write.
- ST_SHIFT to ST_WAIT2 when address bytes remain.
- ST_SHIFT to ST_GUARD when a trailing opcode was sent.
- ST_SHIFT to ST_IDLE otherwise.
- ST_WAIT2 to ST_SHIFT on an accepted write.
- ST_GUARD to ST_WAIT_RB when the count expires.
- ST_WAIT_RB to ST_IDLE when `nand_rb_n` is high.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, `wr_ready`=1, `nand_ce_n`=1, `nand_we_n`=1, and `nand_cle`, `nand_ale`, `nand_io` and `ecc_last` are all 0. While chip enable is high, no strobe, CLE or ALE is driven.
- R2: A write with address bit 19 = 0 is a command phase. It first sends the opcode in address bits 9:2 as one byte with CLE=1 and ALE=0.
- R3: In command phase, address bits 23:21 give the number of address cycles N (0..7). After the opcode, min(N,4) bytes of the write data follow with ALE=1, least-significant byte first.
- R4: When N>4, chip enable stays low and `wr_ready` goes high after the first four address bytes. The next accepted write supplies N-4 further ALE bytes from its data, least-significant byte first. The address of that write is not decoded.
- R5: A write with address bit 19 = 1 is a data phase. It sends its four data bytes, least-significant byte first, with CLE=0 and ALE=0.
- R6: A data-phase write with address bit 20 set drives `ecc_last` high for exactly the one cycle after it is accepted. That cycle is the first strobe-low cycle of its first data byte.
- R7: A data-phase write with address bit 10 set sends the opcode in address bits 18:11 as a CLE byte after its fourth data byte.
- R8: `wr_ready` is low while bytes are being sent. After a trailing opcode, it stays low for TWB_CYC cycles and then until `nand_rb_n` is sampled high, with chip enable held low.
- R9: Each byte holds `nand_io`, CLE and ALE for 2*PULSE_CYC cycles. `nand_we_n` is low for the first PULSE_CYC of those cycles and high for the rest, and `nand_ce_n` is low throughout.
- R10: A write is accepted on a clock edge where both `wr_valid` and `wr_ready` are high. A write presented while `wr_ready` is low is held until it is accepted, and is never lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_addr | input | 24 | Write offset carrying phase, opcodes, count and flags |
| wr_data | input | 32 | Address bytes or data bytes |
| wr_ready | output | 1 | Write can be accepted |
| nand_io | output | 8 | NAND data bus |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the flash |
| ecc_last | output | 1 | One-cycle pulse marking the final ECC chunk |

## Verification
The assertions check on every cycle:
- that CLE and ALE are never high together;
- that the bus is quiet while chip enable is high;
- that each strobe-low window is exactly PULSE_CYC cycles, with the byte held stable through it;
- that `wr_ready` is low whenever a strobe is active;
- that `ecc_last` lasts one cycle and coincides with a data strobe.

Only the bench scenarios can show that the byte values and their order follow the address fields. That covers:
- the split of address bytes across two writes;
- the trailing confirm opcode;
- the guard time and ready/busy wait;
- writes held back during busy periods, without loss or duplication.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
    // Fixed write-offset layout
    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 32;
    localparam int F_OP1_LO   = 2;
    localparam int F_OP2_OK   = 10;
    localparam int F_OP2_LO   = 11;
    localparam int F_PHASE    = 19;
    localparam int F_ECC      = 20;
    localparam int F_NADDR_LO = 21;
    localparam int NADDR_W    = 3;

    typedef enum logic [1:0] {
        BK_DATA = 2'd0,
        BK_CMD  = 2'd1,
        BK_ADDR = 2'd2
    } byte_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_WAIT2,
        ST_GUARD,
        ST_WAIT_RB
    } seq_state_t;

    typedef struct packed {
        logic               is_data;
        logic               ecc_last;
        logic               op2_ok;
        logic [7:0]         op2;
        logic [7:0]         op1;
        logic [NADDR_W-1:0] naddr;
    } wr_fields_t;
endpackage

// File: rtl/nseq_decode.sv
module nseq_decode
    import nseq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output wr_fields_t        fld
);
    logic unused_low;
    assign unused_low = ^addr[F_OP1_LO-1:0];

    assign fld.is_data  = addr[F_PHASE];
    assign fld.ecc_last = addr[F_ECC];
    assign fld.op2_ok   = addr[F_OP2_OK];
    assign fld.op2      = addr[F_OP2_LO +: 8];
    assign fld.op1      = addr[F_OP1_LO +: 8];
    assign fld.naddr    = addr[F_NADDR_LO +: NADDR_W];
endmodule

// File: rtl/nseq_shifter.sv
module nseq_shifter
    import nseq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PULSE = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [$clog2(LANES+2)-1:0]   load_cnt,
    input  logic [LANES:0][7:0]          load_val,
    input  logic [LANES:0][1:0]          load_kind,
    output logic                         active,
    output logic                         last_done,
    output logic [7:0]                   io,
    output byte_kind_t                   kind,
    output logic                         we_n
);
    localparam int SLOTS = LANES + 1;
    localparam int CW    = $clog2(LANES + 2);
    localparam int TW    = (2 * PULSE > 1) ? $clog2(2 * PULSE) : 1;
    localparam logic [TW-1:0] T_END  = TW'(2 * PULSE - 1);
    localparam logic [TW-1:0] T_HALF = TW'(PULSE);

    logic [SLOTS-1:0][7:0] val;
    logic [SLOTS-1:0][1:0] kinds;
    logic [CW-1:0]         cnt;
    logic [TW-1:0]         tmr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val   <= '0;
            kinds <= '0;
            cnt   <= '0;
            tmr   <= '0;
        end else if (load) begin
            val   <= load_val;
            kinds <= load_kind;
            cnt   <= load_cnt;
            tmr   <= '0;
        end else if (cnt != '0) begin
            if (tmr == T_END) begin
                tmr <= '0;
                cnt <= cnt - CW'(1);
                for (int i = 0; i < SLOTS - 1; i++) begin
                    val[i]   <= val[i+1];
                    kinds[i] <= kinds[i+1];
                end
                val[SLOTS-1]   <= '0;
                kinds[SLOTS-1] <= '0;
            end else begin
                tmr <= tmr + TW'(1);
            end
        end
    end

    assign active    = (cnt != '0);
    assign last_done = active && (cnt == CW'(1)) && (tmr == T_END);
    assign io        = active ? val[0] : 8'h00;
    assign kind      = active ? byte_kind_t'(kinds[0]) : BK_DATA;
    assign we_n      = !(active && (tmr < T_HALF));
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
    import nseq_pkg::*;
#(
    parameter int PULSE_CYC = 2,
    parameter int TWB_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic [7:0]        nand_io,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    input  logic              nand_rb_n,
    output logic              ecc_last
);
    localparam int LANES = DATA_W / 8;
    localparam int CW    = $clog2(LANES + 2);
    localparam int GW    = (TWB_CYC > 1) ? $clog2(TWB_CYC) : 1;

    seq_state_t           state, state_nx;
    wr_fields_t           fld;
    logic [NADDR_W-1:0]   addr_rem;
    logic                 trail_pend;
    logic [GW-1:0]        guard_cnt;
    logic                 accept;
    logic [LANES-1:0][7:0] lane;
    logic [LANES:0][7:0]  ld_val;
    logic [LANES:0][1:0]  ld_kind;
    logic [CW-1:0]        ld_cnt;
    logic [NADDR_W-1:0]   first_n;
    logic                 sh_active, sh_last, sh_we_n;
    logic [7:0]           sh_io;
    byte_kind_t           sh_kind;

    nseq_decode u_dec (.addr(wr_addr), .fld(fld));

    genvar g;
    for (g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = wr_data[8*g +: 8];
    end

    assign accept  = wr_valid && wr_ready;
    assign first_n = (fld.naddr > NADDR_W'(LANES)) ? NADDR_W'(LANES) : fld.naddr;

    // Byte list for the shifter
    always_comb begin
        ld_val  = '0;
        ld_kind = '0;
        ld_cnt  = '0;
        if (state == ST_WAIT2) begin
            for (int i = 0; i < LANES; i++) begin
                ld_val[i]  = lane[i];
                ld_kind[i] = BK_ADDR;
            end
            ld_cnt = CW'(addr_rem);
        end else if (fld.is_data) begin
            for (int i = 0; i < LANES; i++) begin
                ld_val[i]  = lane[i];
                ld_kind[i] = BK_DATA;
            end
            ld_val[LANES]  = fld.op2;
            ld_kind[LANES] = BK_CMD;
            ld_cnt = CW'(LANES) + CW'(fld.op2_ok);
        end else begin
            ld_val[0]  = fld.op1;
            ld_kind[0] = BK_CMD;
            for (int i = 0; i < LANES; i++) begin
                ld_val[i+1]  = lane[i];
                ld_kind[i+1] = BK_ADDR;
            end
            ld_cnt = CW'(1) + CW'(first_n);
        end
    end

    nseq_shifter #(.LANES(LANES), .PULSE(PULSE_CYC)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_cnt  (ld_cnt),
        .load_val  (ld_val),
        .load_kind (ld_kind),
        .active    (sh_active),
        .last_done (sh_last),
        .io        (sh_io),
        .kind      (sh_kind),
        .we_n      (sh_we_n)
    );

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_SHIFT;
            ST_SHIFT:   if (sh_last) begin
                            if (addr_rem != '0)  state_nx = ST_WAIT2;
                            else if (trail_pend) state_nx = ST_GUARD;
                            else                 state_nx = ST_IDLE;
                        end
            ST_WAIT2:   if (accept) state_nx = ST_SHIFT;
            ST_GUARD:   if (guard_cnt == GW'(TWB_CYC - 1)) state_nx = ST_WAIT_RB;
            ST_WAIT_RB: if (nand_rb_n) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register and phase bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            addr_rem   <= '0;
            trail_pend <= 1'b0;
            guard_cnt  <= '0;
            ecc_last   <= 1'b0;
        end else begin
            state     <= state_nx;
            ecc_last  <= accept && (state == ST_IDLE) && fld.is_data && fld.ecc_last;
            guard_cnt <= (state == ST_GUARD) ? guard_cnt + GW'(1) : '0;
            if (accept && state == ST_IDLE) begin
                addr_rem   <= (!fld.is_data && fld.naddr > NADDR_W'(LANES))
                              ? fld.naddr - NADDR_W'(LANES) : '0;
                trail_pend <= fld.is_data && fld.op2_ok;
            end else if (accept && state == ST_WAIT2) begin
                addr_rem <= '0;
            end else if (state == ST_GUARD) begin
                trail_pend <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        wr_ready  = (state == ST_IDLE) || (state == ST_WAIT2);
        nand_ce_n = (state == ST_IDLE);
        nand_io   = sh_io;
        nand_we_n = sh_we_n;
        nand_cle  = sh_active && (sh_kind == BK_CMD);
        nand_ale  = sh_active && (sh_kind == BK_ADDR);
    end
endmodule

// File: rtl/nseq_checks.sv
module nseq_checks #(
    parameter int PULSE_CYC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ready,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic [7:0] nand_io,
    input logic       ecc_last
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= '0;
        else if (!nand_we_n) low_run <= low_run + 16'd1;
        else                 low_run <= '0;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n |-> (nand_we_n && !nand_cle && !nand_ale));

    p_cle_ale_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_ready_low_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !wr_ready);

    p_we_low_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (low_run == 16'(PULSE_CYC)));

    p_io_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_io));

    p_ecc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_last |=> !ecc_last);

    p_ecc_with_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_last |-> (!nand_we_n && !nand_cle && !nand_ale));
endmodule

bind nand_addr_seq nseq_checks #(.PULSE_CYC(PULSE_CYC)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ready  (wr_ready),
    .nand_ce_n (nand_ce_n),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_we_n (nand_we_n),
    .nand_io   (nand_io),
    .ecc_last  (ecc_last)
);

// File: tb/nand_addr_seq_test.sv
`timescale 1ns/1ps
module nand_addr_seq_test;
    localparam int P   = 2;
    localparam int TWB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        nand_rb_n = 1'b1;
    logic        wr_ready, nand_ce_n, nand_cle, nand_ale, nand_we_n, ecc_last;
    logic [7:0]  nand_io;

    always #2.5 clk = ~clk;

    nand_addr_seq #(.PULSE_CYC(P), .TWB_CYC(TWB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .nand_io(nand_io),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_rb_n(nand_rb_n), .ecc_last(ecc_last)
    );

    typedef struct {
        logic [7:0] io;
        logic       cle;
        logic       ale;
        logic       we_n;
        int         req;
    } cyc_t;

    // Reference model state: expected strobe waveform as a queue of cycles
    cyc_t wave[$];
    int   mode;   // 0 idle, 1 sending, 2 wait second write, 3 guard, 4 wait ready
    int   rem2, gcnt, nadr;
    bit   trail, m_ecc, m_took, live;
    int   n_err = 0, n_chk = 0, n_acc = 0, n_issued = 0;

    function automatic void push_byte(logic [7:0] v, bit c, bit a, int req);
        for (int i = 0; i < 2 * P; i++) begin
            cyc_t e;
            e.io = v; e.cle = c; e.ale = a; e.we_n = (i >= P); e.req = req;
            wave.push_back(e);
        end
    endfunction

    function automatic void chk(int req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0; wave.delete(); rem2 = 0; trail = 0; m_ecc = 0; m_took = 0; gcnt = 0;
            live = 0;
        end else begin
            live = 1; m_took = 0; m_ecc = 0;
            case (mode)
                0: if (wr_valid) begin
                    m_took = 1; n_acc++;
                    if (wr_addr[19]) begin
                        // R5 data bytes, R7 trailing opcode, R6 ecc pulse
                        for (int b = 0; b < 4; b++) push_byte(wr_data[8*b +: 8], 0, 0, 5);
                        if (wr_addr[10]) push_byte(wr_addr[18:11], 1, 0, 7);
                        trail = wr_addr[10];
                        m_ecc = wr_addr[20];
                        rem2  = 0;
                    end else begin
                        // R2 opcode then R3 address bytes
                        nadr = int'(wr_addr[23:21]);
                        push_byte(wr_addr[9:2], 1, 0, 2);
                        for (int b = 0; b < ((nadr > 4) ? 4 : nadr); b++)
                            push_byte(wr_data[8*b +: 8], 0, 1, 3);
                        rem2  = (nadr > 4) ? nadr - 4 : 0;
                        trail = 0;
                    end
                    mode = 1;
                end
                2: if (wr_valid) begin
                    m_took = 1; n_acc++;
                    // R4 remaining address bytes from the second write
                    for (int b = 0; b < rem2; b++) push_byte(wr_data[8*b +: 8], 0, 1, 4);
                    rem2 = 0;
                    mode = 1;
                end
                1: begin
                    void'(wave.pop_front());
                    if (wave.size() == 0) begin
                        if (rem2 > 0) mode = 2;
                        else if (trail) begin trail = 0; gcnt = TWB; mode = 3; end
                        else mode = 0;
                    end
                end
                3: begin
                    gcnt--;
                    if (gcnt == 0) mode = 4;
                end
                4: if (nand_rb_n) mode = 0;
                default: mode = 0;
            endcase
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            cyc_t e;
            int   rq;
            if (mode == 1) e = wave[0];
            else begin
                e.io = 8'h00; e.cle = 0; e.ale = 0; e.we_n = 1;
                e.req = (mode == 0) ? 1 : (mode == 2) ? 4 : 8;
            end
            // R9 strobe shape carried by each expected byte
            chk(e.req, "bus {io,cle,ale,we_n}", {21'd0, nand_io, nand_cle, nand_ale, nand_we_n},
                {21'd0, e.io, e.cle, e.ale, e.we_n});
            chk(9, "ce_n", {31'd0, nand_ce_n}, {31'd0, (mode == 0)});
            rq = (mode == 0 || mode == 2) ? 10 : 8;   // R10 accept window, R8 busy
            chk(rq, "wr_ready", {31'd0, wr_ready}, {31'd0, (mode == 0 || mode == 2)});
            chk(6, "ecc_last", {31'd0, ecc_last}, {31'd0, m_ecc});
        end
    end

    task automatic do_write(logic [23:0] a, logic [31:0] d);
        @(negedge clk);
        wr_valid = 1; wr_addr = a; wr_data = d; n_issued++;
        do begin @(posedge clk); #0.5; end while (!m_took);
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (mode != 0);
    endtask

    function automatic logic [23:0] cmd_at(logic [7:0] op, int n);
        return (24'(n) << 21) | (24'(op) << 2);
    endfunction

    function automatic logic [23:0] dat_at(bit ecc, bit ok, logic [7:0] op2);
        return (24'd1 << 19) | (24'(ecc) << 20) | (24'(ok) << 10) | (24'(op2) << 11);
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(1, "reset ready", {31'd0, wr_ready}, 32'd1);
        chk(1, "reset ce_n", {31'd0, nand_ce_n}, 32'd1);
        chk(1, "reset we_n", {31'd0, nand_we_n}, 32'd1);
        chk(1, "reset cle/ale/io", {22'd0, nand_cle, nand_ale, nand_io}, 32'd0);
        chk(1, "reset ecc", {31'd0, ecc_last}, 32'd0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        do_write(cmd_at(8'hFF, 0), 32'h0);               // R2 opcode only
        do_write(cmd_at(8'h90, 1), 32'hDEADBE20);        // R3 one address byte
        do_write(cmd_at(8'h00, 4), 32'h44332211);        // R3 four bytes
        do_write(cmd_at(8'h80, 5), 32'hA4A3A2A1);        // R4 split, one more byte
        do_write(24'hFFFFFF, 32'h000000A5);
        do_write(cmd_at(8'h85, 7), 32'h0F0E0D0C);        // R4 split, three more bytes
        do_write(24'h000000, 32'h00C3B2A1);
        do_write(dat_at(0, 0, 8'h00), 32'h01234567);     // R5 back-to-back, R10 stall
        do_write(dat_at(0, 0, 8'h00), 32'h89ABCDEF);
        do_write(dat_at(1, 0, 8'h00), 32'h5A5AA5A5);     // R6 ecc pulse
        do_write(dat_at(1, 1, 8'h10), 32'hCAFEF00D);     // R7 confirm, R8 busy wait
        @(negedge clk); nand_rb_n = 0;
        repeat (60) @(negedge clk);
        nand_rb_n = 1;
        wait_idle();
        do_write(dat_at(0, 1, 8'h15), 32'h13579BDF);     // R7 with ready already high
        wait_idle();
        do_write(cmd_at(8'h70, 0), 32'h0);
        wait_idle();
        repeat (4) @(negedge clk);
        chk(10, "accepted writes", 32'(n_acc), 32'(n_issued));   // R10

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R8 watchdog: actual 0 expected 1 (run completion)");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule